// File: doc/BRIEF.md
# Packed Double-Element Lane Shuffle

This block is one pipeline stage of a vector datapath. It assembles a 256-bit result from four 64-bit elements. Each element comes from one of two source vectors, and bits of an 8-bit immediate pick which element is used. In every 128-bit lane, the lower result element can come only from the first source vector, and the upper result element can come only from the second. Each lane makes its own choice, using its own pair of immediate bits. Elements are moved as raw bit patterns. No value is ever treated as a number, so no arithmetic condition can occur.

A 2-bit mode sets how far the shuffle reaches:
- In the two narrow modes, only the bottom lane is shuffled. The top half of the result either keeps the prior destination value or is cleared.
- In the wide mode, both lanes are shuffled.
- One mode code is illegal. It gives a cleared result and raises a flag.

The result and the valid flag are registered together. A new result therefore appears exactly one clock after it is presented at the inputs.

Top module: `pdshuf_unit`

## Requirements
- R1: Result bits 63:0 equal `src_a[63:0]` when `imm[0]` is 0 and `src_a[127:64]` when it is 1, copied bit-exactly, in every mode except the illegal one.
- R2: Result bits 127:64 equal `src_b[63:0]` when `imm[1]` is 0 and `src_b[127:64]` when it is 1, in every mode except the illegal one.
- R3: With `mode` = 2'b10 (wide), result bits 191:128 equal `src_a[191:128]` when `imm[2]` is 0 and `src_a[255:192]` when it is 1.
- R4: With `mode` = 2'b10, result bits 255:192 equal `src_b[191:128]` when `imm[3]` is 0 and `src_b[255:192]` when it is 1.
- R5: With `mode` = 2'b00 (narrow, keep), result bits 255:128 equal `prior_dst[255:128]`.
- R6: With `mode` = 2'b01 (narrow, clear), result bits 255:128 are zero.
- R7: In the narrow modes, `imm[7:2]` has no effect on the result. In the wide mode, `imm[7:4]` has no effect on the result.
- R8: With `mode` = 2'b11, the whole result is zero and `out_bad_mode` is 1 together with `out_valid`. In all other modes, `out_bad_mode` is 0.
- R9: `out_valid` equals `in_valid` delayed by exactly one clock. A synchronous active-high `rst` clears `out_valid`, `out_bad_mode` and `out_result`.
- R10: While `in_valid` is 0, `out_result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| mode | input | 2 | 00 narrow keep, 01 narrow clear, 10 wide, 11 illegal |
| imm | input | 8 | Element select immediate |
| src_a | input | 256 | First source vector (feeds the low element of each lane) |
| src_b | input | 256 | Second source vector (feeds the high element of each lane) |
| prior_dst | input | 256 | Previous destination value, kept in narrow keep mode |
| out_valid | output | 1 | Registered result is valid |
| out_bad_mode | output | 1 | The result came from the illegal mode code |
| out_result | output | 256 | Registered shuffle result |

## Verification
Every result, and the flag for the illegal mode, is due on the first rising edge after the edge that sampled `in_valid` high. The bench drives the operands on a falling edge and reads the outputs on the next falling edge, half a period after the capturing edge. It then drops `in_valid` and reads again at the following falling edge. That second read shows `out_valid` low and the result held. The expected values come from a separate reference function built from the requirements, applied to table vectors, to directed cases for reserved immediate bits and raw bit patterns, and to a random sweep.

// File: rtl/pdshuf_pkg.sv
`timescale 1ns/1ps
package pdshuf_pkg;
   typedef enum logic [1:0] {
      MODE_KEEP = 2'b00,
      MODE_ZERO = 2'b01,
      MODE_FULL = 2'b10,
      MODE_BAD  = 2'b11
   } shuf_mode_e;
endpackage

// File: rtl/pdshuf_pair_sel.sv
`timescale 1ns/1ps
module pdshuf_pair_sel #(
   parameter int ELEM_W = 64
) (
   input  logic [2*ELEM_W-1:0] pair,
   input  logic                sel,
   output logic [ELEM_W-1:0]   elem
);
   always_comb begin
      if (sel) elem = pair[2*ELEM_W-1:ELEM_W];
      else     elem = pair[ELEM_W-1:0];
   end
endmodule

// File: rtl/pdshuf_lane.sv
`timescale 1ns/1ps
module pdshuf_lane #(
   parameter int ELEM_W = 64,
   localparam int LANE_W = 2*ELEM_W
) (
   input  logic [LANE_W-1:0] a_lane,
   input  logic [LANE_W-1:0] b_lane,
   input  logic [1:0]        sel,
   output logic [LANE_W-1:0] lane_out
);
   logic [ELEM_W-1:0] lo_elem, hi_elem;

   pdshuf_pair_sel #(.ELEM_W(ELEM_W)) u_lo (
      .pair(a_lane), .sel(sel[0]), .elem(lo_elem));
   pdshuf_pair_sel #(.ELEM_W(ELEM_W)) u_hi (
      .pair(b_lane), .sel(sel[1]), .elem(hi_elem));

   assign lane_out = {hi_elem, lo_elem};
endmodule

// File: rtl/pdshuf_fill.sv
`timescale 1ns/1ps
module pdshuf_fill
   import pdshuf_pkg::*;
#(
   parameter int LANE_W  = 128,
   parameter bit IS_BASE = 1'b0
) (
   input  shuf_mode_e        mode,
   input  logic [LANE_W-1:0] shuffled,
   input  logic [LANE_W-1:0] prior,
   output logic [LANE_W-1:0] lane_next
);
   generate
      if (IS_BASE) begin : g_base
         always_comb begin
            if (mode == MODE_BAD) lane_next = '0;
            else                  lane_next = shuffled;
         end
      end else begin : g_upper
         always_comb begin
            unique case (mode)
               MODE_KEEP: lane_next = prior;
               MODE_FULL: lane_next = shuffled;
               default:   lane_next = '0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/pdshuf_unit.sv
`timescale 1ns/1ps
module pdshuf_unit
   import pdshuf_pkg::*;
#(
   parameter int ELEM_W    = 64,
   parameter int NUM_LANES = 2,
   parameter int IMM_W     = 8,
   localparam int LANE_W   = 2*ELEM_W,
   localparam int VEC_W    = LANE_W*NUM_LANES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [1:0]       mode,
   input  logic [IMM_W-1:0] imm,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [VEC_W-1:0] prior_dst,
   output logic             out_valid,
   output logic             out_bad_mode,
   output logic [VEC_W-1:0] out_result
);
   generate
      if (IMM_W < 2*NUM_LANES) begin : g_chk_imm
         $error("pdshuf_unit: IMM_W too narrow for NUM_LANES");
      end
      if (NUM_LANES < 1 || ELEM_W < 1) begin : g_chk_size
         $error("pdshuf_unit: NUM_LANES and ELEM_W must be positive");
      end
   endgenerate

   shuf_mode_e        mode_e;
   logic [VEC_W-1:0]  next_result;

   assign mode_e = shuf_mode_e'(mode);

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic [LANE_W-1:0] shuffled;

      pdshuf_lane #(.ELEM_W(ELEM_W)) u_lane (
         .a_lane   (src_a[g*LANE_W +: LANE_W]),
         .b_lane   (src_b[g*LANE_W +: LANE_W]),
         .sel      (imm[2*g +: 2]),
         .lane_out (shuffled));

      pdshuf_fill #(.LANE_W(LANE_W), .IS_BASE(g == 0)) u_fill (
         .mode      (mode_e),
         .shuffled  (shuffled),
         .prior     (prior_dst[g*LANE_W +: LANE_W]),
         .lane_next (next_result[g*LANE_W +: LANE_W]));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         out_bad_mode <= 1'b0;
         out_result   <= '0;
      end else begin
         out_valid    <= in_valid;
         out_bad_mode <= in_valid && (mode_e == MODE_BAD);
         if (in_valid) out_result <= next_result;
      end
   end

   // R9: one-cycle latency of the valid flag
   a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r9_valid_idle: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R10: result is held between valid inputs
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_result));

   // R8: flag only accompanies a valid all-zero result
   a_r8_bad_zero: assert property (@(posedge clk) disable iff (rst)
      out_bad_mode |-> (out_valid && out_result == '0));

   // R1: bottom element always drawn from the first source
   a_r1_low_elem: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode != 2'b11) |=>
         out_result[ELEM_W-1:0] ==
            ($past(imm[0]) ? $past(src_a[LANE_W-1:ELEM_W]) : $past(src_a[ELEM_W-1:0])));

   generate
      if (NUM_LANES > 1) begin : g_upper_chk
         // R5: keep mode preserves the prior top half
         a_r5_keep_upper: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode == 2'b00) |=>
               out_result[VEC_W-1:LANE_W] == $past(prior_dst[VEC_W-1:LANE_W]));
         // R6: clear mode zeroes the top half
         a_r6_zero_upper: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode == 2'b01) |=> out_result[VEC_W-1:LANE_W] == '0);
      end
   endgenerate
endmodule

// File: tb/tb_pdshuf_unit.sv
`timescale 1ns/1ps
module tb_pdshuf_unit;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [1:0]   mode;
   logic [7:0]   imm;
   logic [255:0] src_a, src_b, prior_dst;
   logic         out_valid, out_bad_mode;
   logic [255:0] out_result;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   pdshuf_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .imm(imm),
      .src_a(src_a), .src_b(src_b), .prior_dst(prior_dst),
      .out_valid(out_valid), .out_bad_mode(out_bad_mode), .out_result(out_result));

   // {mode, imm} stimulus vectors
   localparam logic [9:0] VECS [10] = '{
      {2'b00, 8'h00}, {2'b00, 8'h03}, {2'b01, 8'h01}, {2'b01, 8'h02},
      {2'b10, 8'h00}, {2'b10, 8'h0F}, {2'b10, 8'h05}, {2'b10, 8'h0A},
      {2'b11, 8'h0F}, {2'b00, 8'hFC}
   };

   function automatic logic [255:0] ref_model(input logic [1:0] m, input logic [7:0] s,
                                              input logic [255:0] a, input logic [255:0] b,
                                              input logic [255:0] d);
      logic [255:0] r;
      r[63:0]   = s[0] ? a[127:64] : a[63:0];
      r[127:64] = s[1] ? b[127:64] : b[63:0];
      case (m)
         2'b00: r[255:128] = d[255:128];
         2'b01: r[255:128] = '0;
         2'b10: begin
            r[191:128] = s[2] ? a[255:192] : a[191:128];
            r[255:192] = s[3] ? b[255:192] : b[191:128];
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic logic [255:0] pattern(input logic [7:0] tag);
      return {tag, 56'hA3_0000_0000_0003, tag, 56'hA2_0000_0000_0002,
              tag, 56'hA1_0000_0000_0001, tag, 56'hA0_0000_0000_0000};
   endfunction

   task automatic check(input bit ok, input string req, input logic [255:0] act,
                        input logic [255:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive on a falling edge, read one falling edge later, then drop valid.
   task automatic apply(input logic [1:0] m, input logic [7:0] s, input logic [255:0] a,
                        input logic [255:0] b, input logic [255:0] d, input string req);
      logic [255:0] exp;
      exp = ref_model(m, s, a, b, d);
      @(negedge clk);
      mode = m; imm = s; src_a = a; src_b = b; prior_dst = d; in_valid = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b1, "R9 valid latency", {255'd0, out_valid}, 256'd1);
      check(out_result === exp, req, out_result, exp);
      check(out_bad_mode === (m == 2'b11), "R8 flag", {255'd0, out_bad_mode},
            {255'd0, m == 2'b11});
      in_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [255:0] held;
      rst = 1'b1; in_valid = 1'b0; mode = '0; imm = '0;
      src_a = '0; src_b = '0; prior_dst = '0;
      repeat (3) @(negedge clk);
      // R9: reset state
      check(out_valid === 1'b0, "R9 reset valid", {255'd0, out_valid}, 256'd0);
      check(out_bad_mode === 1'b0, "R9 reset flag", {255'd0, out_bad_mode}, 256'd0);
      check(out_result === '0, "R9 reset result", out_result, 256'd0);
      rst = 1'b0;

      // Table walk: R1 R2 R3 R4 R5 R6 R8
      for (int i = 0; i < 10; i++) begin
         apply(VECS[i][9:8], VECS[i][7:0], pattern(8'h10 + 8'(i)), pattern(8'h80 + 8'(i)),
               pattern(8'hD0 + 8'(i)), "R1 R2 R3 R4 R5 R6 R8 table");
      end

      // R7: reserved immediate bits in narrow modes
      apply(2'b00, 8'hFE, pattern(8'h21), pattern(8'h22), pattern(8'h23), "R7 keep reserved");
      apply(2'b01, 8'hA9, pattern(8'h24), pattern(8'h25), pattern(8'h26), "R7 clear reserved");
      // R7: upper immediate bits in wide mode
      apply(2'b10, 8'hF6, pattern(8'h27), pattern(8'h28), pattern(8'h29), "R7 wide reserved");

      // R1 R2 R3 R4: raw NaN and denormal bit patterns copied exactly
      apply(2'b10, 8'h0F,
            {64'h7FF0_0000_0000_0001, 64'h0000_0000_0000_0001,
             64'hFFF8_0000_0000_0000, 64'h8000_0000_0000_0000},
            {64'h7FF8_DEAD_BEEF_0001, 64'h000F_FFFF_FFFF_FFFF,
             64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
            '0, "R1 R2 R3 R4 raw patterns");

      // R10: result held while in_valid is low; R9 valid drops
      apply(2'b10, 8'h06, pattern(8'h31), pattern(8'h32), pattern(8'h33), "R3 R4 wide");
      held = out_result;
      src_a = '1; src_b = '1; prior_dst = '1; mode = 2'b10; imm = 8'hFF;
      @(negedge clk);
      check(out_valid === 1'b0, "R9 valid drop", {255'd0, out_valid}, 256'd0);
      check(out_result === held, "R10 hold", out_result, held);
      @(negedge clk);
      check(out_result === held, "R10 hold second cycle", out_result, held);

      // R5 R6 R8: illegal mode then keep mode
      apply(2'b11, 8'h00, '1, '1, '1, "R8 illegal zero");
      apply(2'b00, 8'h01, '1, pattern(8'h41), pattern(8'h42), "R5 keep after illegal");

      // Random sweep against the reference model
      for (int k = 0; k < 300; k++) begin
         logic [255:0] ra, rb, rd;
         for (int w = 0; w < 8; w++) begin
            ra[w*32 +: 32] = $urandom;
            rb[w*32 +: 32] = $urandom;
            rd[w*32 +: 32] = $urandom;
         end
         apply(2'($urandom), 8'($urandom), ra, rb, rd, "R1 R2 R3 R4 R5 R6 R7 R8 random");
      end

      // R9: synchronous reset clears the outputs
      @(negedge clk);
      mode = 2'b11; in_valid = 1'b1; rst = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "R9 reset over valid", {255'd0, out_valid}, 256'd0);
      check(out_bad_mode === 1'b0, "R9 reset over flag", {255'd0, out_bad_mode}, 256'd0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule